// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Generator

This block drives four pulse-width-modulated outputs from one shared counter. The counter steps once every 2^N clock cycles, where N is a 3-bit prescale exponent. It counts either as a sawtooth (0 up to the top value, then back to 0) or as a triangle for center-aligned pulses (up to the top value, then back down). Each channel is set by a 16-bit word. The low fifteen bits hold the compare threshold. The most significant bit selects whether the active level is high or low.

Configuration arrives on plain ports and is held in a shadow copy when the load strobe is high. The shadow copy becomes the working copy only at a period boundary, or when a start is accepted, so no period mixes old and new settings. A stop request does not cut a period short. The current period runs to its end, and any start seen before that end is dropped. Once stopped, every output rests at its channel's idle level until the next start.

Top module: `pwm_core`

## Requirements
- R1: After reset, `stopped` is 1 and every output is low. The reset channel word is 0x8000: compare 0, active level high.
- R2: In a channel word, bits [14:0] are the compare value and bit 15 selects the active level. 1 means active-high and 0 means active-low. The idle (inactive) level is always the opposite of the active level.
- R3: In sawtooth mode (`cfg_updown`=0) with top value T, the counter visits 0,1,...,T and then wraps, so a period lasts T+1 counter steps. A channel is active while the counter is below its compare value.
- R4: In triangle mode (`cfg_updown`=1) with T≥1, the counter visits 0..T and then T-1..1, so a period lasts 2·T counter steps. The same below-compare rule applies.
- R5: The counter advances once every 2^N clock cycles, where N is `cfg_prescale`. The first step comes 2^N cycles after the start is accepted.
- R6: While running, a compare value of 0 keeps the channel idle for the whole period. A compare value at or above T keeps it active for the whole period.
- R7: Channel words, top value, prescale and mode are staged by `cfg_load`. They take effect only at the next period wrap that comes at least one cycle after the staging edge, or at an accepted start.
- R8: A stop request takes effect at the first period wrap on or after the edge that samples it. `stopped` is 1 from that edge on.
- R9: A start request that arrives while a stop is pending has no effect. Generation continues uninterrupted until the pending stop completes.
- R10: While stopped, each output sits at its channel's idle level. An accepted start begins a fresh period with the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_updown | input | 1 | Counting mode: 0 sawtooth, 1 triangle |
| cfg_prescale | input | 3 | Prescale exponent N (step every 2^N cycles) |
| cfg_top | input | 15 | Counter top value T |
| cfg_words | input | 64 | Four channel words, channel i at bits [16i+15:16i] |
| cfg_load | input | 1 | Stage the cfg_* values into the shadow copy |
| start | input | 1 | Begin generation when stopped |
| stop | input | 1 | Request a stop at the end of the current period |
| pwm_out | output | 4 | Channel outputs |
| stopped | output | 1 | 1 while no generation is taking place |

## Verification
The bench sweeps both counting modes, prescale exponents 0 to 2 and several top values. On each pass it compares every output in every cycle against a closed-form position-in-period formula. The channel mix is fixed: a zero compare, a compare of 1 with active-low polarity, a compare above the top value, and a mid-range compare. This mix separates the constant-level cases from true modulation and shows polarity errors. Each pass restages rotated words just after the start, which shows whether the transfer waits for the wrap. It then issues a stop followed by a start while the stop is pending. That exposes an early stop, a missing stop, or a restart of the counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CMP_W  = 15;
    localparam int WORD_W = CMP_W + 1;
    localparam int PRE_W  = 3;

    typedef struct packed {
        logic             pol;
        logic [CMP_W-1:0] cmp;
    } ch_word_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = CMP_W,
    parameter int PS_W  = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             updn_i,
    input  logic [PS_W-1:0]  presc_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             running_o,
    output logic             accept_o,
    output logic             wrap_o
);

    localparam int PCNT_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic              running;
        logic              pend;
        logic              dn;
        logic [CNT_W-1:0]  cnt;
        logic [PCNT_W-1:0] pcnt;
    } tb_state_t;

    tb_state_t         q, d;
    logic              tick;
    logic              wrap;
    logic              accept;
    logic [PCNT_W-1:0] tick_lim;

    always_comb begin
        tick_lim = PCNT_W'((32'd1 << presc_i) - 32'd1);
        tick     = (q.pcnt == tick_lim);
        accept   = start_i && !q.running;
        wrap     = 1'b0;
        d        = q;
        if (accept) begin
            d.running = 1'b1;
            d.pend    = 1'b0;
            d.dn      = 1'b0;
            d.cnt     = '0;
            d.pcnt    = '0;
        end else if (q.running) begin
            d.pcnt = tick ? '0 : q.pcnt + PCNT_W'(1);
            d.pend = q.pend | stop_i;
            if (tick) begin
                if (!updn_i) begin
                    if (q.cnt >= top_i) begin
                        wrap  = 1'b1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else if (!q.dn) begin
                    if (q.cnt >= top_i) begin
                        if (top_i <= CNT_W'(1)) begin
                            wrap  = 1'b1;
                            d.cnt = '0;
                        end else begin
                            d.cnt = top_i - CNT_W'(1);
                            d.dn  = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    if (q.cnt <= CNT_W'(1)) begin
                        wrap  = 1'b1;
                        d.cnt = '0;
                        d.dn  = 1'b0;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
            end
            if (wrap && d.pend) begin
                d.running = 1'b0;
                d.pend    = 1'b0;
                d.dn      = 1'b0;
                d.cnt     = '0;
                d.pcnt    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o     = q.cnt;
    assign running_o = q.running;
    assign accept_o  = accept;
    assign wrap_o    = wrap;

    // R5
    step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.running && !tick) |=> $stable(q.cnt));

    // R3
    up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.running && !updn_i) |-> (q.cnt <= top_i));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !wrap) |=> (q.running && q.pend));

    // R8
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.running) |-> $past(wrap && (q.pend || stop_i)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = CMP_W
) (
    input  ch_word_t         word_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             running_i,
    output logic             out_o
);

    logic active;

    always_comb begin
        active = running_i && (word_i.cmp != '0) &&
                 ((word_i.cmp >= top_i) || (cnt_i < word_i.cmp));
        out_o  = active ? word_i.pol : !word_i.pol;
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_updown,
    input  logic [PRE_W-1:0]      cfg_prescale,
    input  logic [CMP_W-1:0]      cfg_top,
    input  logic [NCH*WORD_W-1:0] cfg_words,
    input  logic                  cfg_load,
    input  logic                  start,
    input  logic                  stop,
    output logic [NCH-1:0]        pwm_out,
    output logic                  stopped
);

    typedef struct packed {
        logic                  updn;
        logic [PRE_W-1:0]      presc;
        logic [CMP_W-1:0]      top;
        logic [NCH*WORD_W-1:0] words;
    } cfg_t;

    typedef struct packed {
        cfg_t shadow;
        cfg_t act;
    } core_state_t;

    localparam cfg_t RST_CFG = '{
        updn:  1'b0,
        presc: '0,
        top:   '0,
        words: {NCH{1'b1, {CMP_W{1'b0}}}}
    };

    core_state_t      q, d;
    logic [CMP_W-1:0] cnt;
    logic             running;
    logic             accept;
    logic             wrap;

    always_comb begin
        d = q;
        if (cfg_load) d.shadow = '{cfg_updown, cfg_prescale, cfg_top, cfg_words};
        if (accept || wrap) d.act = q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{RST_CFG, RST_CFG};
        else        q <= d;
    end

    pwm_timebase #(.CNT_W(CMP_W), .PS_W(PRE_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .stop_i    (stop),
        .updn_i    (q.act.updn),
        .presc_i   (q.act.presc),
        .top_i     (q.act.top),
        .cnt_o     (cnt),
        .running_o (running),
        .accept_o  (accept),
        .wrap_o    (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CMP_W)) u_ch (
            .word_i    (ch_word_t'(q.act.words[g*WORD_W +: WORD_W])),
            .cnt_i     (cnt),
            .top_i     (q.act.top),
            .running_i (running),
            .out_o     (pwm_out[g])
        );
    end

    assign stopped = !running;

    // R7
    act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap && !accept) |=> $stable(q.act));

    // R10
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (cnt == '0));

endmodule

// File: tb/pwm_core_bench.sv
`timescale 1ns/1ps
module pwm_core_bench;

    localparam int NCH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_updown = 1'b0;
    logic [2:0]    cfg_prescale = '0;
    logic [14:0]   cfg_top = '0;
    logic [63:0]   cfg_words = '0;
    logic          cfg_load = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [NCH-1:0] pwm_out;
    logic          stopped;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pwm_core #(.NCH(NCH)) u_pwm_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_updown   (cfg_updown),
        .cfg_prescale (cfg_prescale),
        .cfg_top      (cfg_top),
        .cfg_words    (cfg_words),
        .cfg_load     (cfg_load),
        .start        (start),
        .stop         (stop),
        .pwm_out      (pwm_out),
        .stopped      (stopped)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int period_of(bit md, int t);
        if (md) return (t == 0) ? 1 : 2 * t;
        return t + 1;
    endfunction

    function automatic bit exp_bit(bit md, int n, int t, int k, logic [15:0] w);
        int p   = period_of(md, t);
        int pos = (k >> n) % p;
        int c   = (md && pos > t) ? 2 * t - pos : pos;
        int cmp = int'(w[14:0]);
        bit act = (cmp != 0) && ((cmp >= t) || (c < cmp));
        return act ? w[15] : !w[15];
    endfunction

    function automatic logic [63:0] mkw(int t, int rot);
        logic [15:0] a [4];
        logic [63:0] r;
        a[0] = {1'b1, 15'd0};
        a[1] = {1'b0, 15'd1};
        a[2] = {1'b1, 15'(t + 1)};
        a[3] = {1'(t & 1), 15'(t / 2 + 1)};
        for (int i = 0; i < 4; i++) r[i*16 +: 16] = a[(i + rot) % 4];
        return r;
    endfunction

    task automatic run_cfg(bit md, int n, int t);
        logic [63:0] w_old = mkw(t, 0);
        logic [63:0] w_new = mkw(t, 1);
        int L = period_of(md, t) << n;
        int kw = L;
        int ks;
        int kstop;
        while (kw < 3) kw += L;
        ks = kw + 1;
        kstop = L;
        while (kstop < ks + 1) kstop += L;

        @(negedge clk);
        cfg_updown = md; cfg_prescale = 3'(n); cfg_top = 15'(t);
        cfg_words = w_old; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= kstop + 3; k++) begin
            logic [63:0] wk;
            if (k > 0) @(negedge clk);
            wk = (k >= kw) ? w_new : w_old;
            chk("R8", 32'(stopped), 32'(k >= kstop), "stopped flag");
            for (int c = 0; c < NCH; c++) begin
                logic [15:0] w = wk[c*16 +: 16];
                bit e;
                string tg;
                if (k >= kstop) begin
                    e = !w[15];
                    tg = "R10";
                end else begin
                    e = exp_bit(md, n, t, k, w);
                    if (k >= ks + 2)                               tg = "R9";
                    else if (w[14:0] == 0 || int'(w[14:0]) >= t)   tg = "R6";
                    else if (!w[15])                               tg = "R2";
                    else if (k >= kw)                              tg = "R7";
                    else if (n > 0)                                tg = "R5";
                    else if (md)                                   tg = "R4";
                    else                                           tg = "R3";
                end
                chk(tg, 32'(pwm_out[c]), 32'(e),
                    $sformatf("ch%0d md=%0d n=%0d t=%0d k=%0d", c, md, n, t, k));
            end
            if (k == 1) begin
                cfg_words = w_new; cfg_load = 1'b1;
            end else begin
                cfg_load = 1'b0;
            end
            stop  = (k == ks);
            start = (k == ks + 1) && (ks + 2 <= kstop);
        end
        stop = 1'b0; start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int tops [4] = '{1, 2, 3, 6};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(stopped), 32'd1, "stopped after reset");
        chk("R1", 32'(pwm_out), 32'd0, "outputs after reset");
        for (int md = 0; md < 2; md++)
            for (int n = 0; n < 3; n++)
                for (int ti = 0; ti < 4; ti++)
                    run_cfg(md[0], n, tops[ti]);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule